// File: doc/BRIEF.md
# Load/Store Queue Dependence Check

This block tracks in-flight memory operations of an out-of-order core in program order. At dispatch each load or store takes the next queue slot. Once register operands are ready, the address generator writes the effective address into that slot. The queue then decides on its own when a load may be sent to the data cache and when a store may update memory.

A load leaves only when no older store could touch the same word. An older store whose address is still unknown counts as a possible match. A store reaches memory only after the reorder logic has committed it, because a memory write cannot be undone if an earlier instruction later faults. Committed entries leave the head one per cycle. A committed store drives its address on the write port in the cycle it leaves. A flush throws away every entry younger than a given slot, for example after a mispredicted branch.

Top module: `lsq_dep_check`

## Requirements
- R1: After a synchronous active-high reset the queue is empty: `alloc_ready` is 1, `alloc_slot` is 0, and both `ld_issue_valid` and `st_write_valid` are 0.
- R2: Each accepted allocation takes slot `alloc_slot`, which then advances by one modulo 16. `alloc_ready` is 0 while all 16 slots are held. A request made while the queue is full, or in a flush cycle, is ignored and leaves `alloc_slot` unchanged.
- R3: A load can issue only after its address has been written through the address port, at the earliest in the following cycle. Each load issues at most once.
- R4: An older store whose address is still unknown blocks every younger load. Stores that are younger than a load never block it.
- R5: An older store with a known address blocks a load when the two addresses agree in bits [31:2]. A difference in bits [1:0] alone does not unblock the load.
- R6: At most one load issues per cycle. It is the oldest eligible load in program order, and its slot and address are presented on the issue outputs.
- R7: `commit_valid` marks the oldest uncommitted entry. A store is written, with its address on `st_write_addr`, only once it is committed and at the head, which is at the earliest the cycle after its commit. At most one entry leaves the head per cycle.
- R8: A committed load leaves the head without raising `st_write_valid`.
- R9: A flush keeps slot `flush_slot` and everything older, and discards every younger entry. The next allocation receives `flush_slot`+1 modulo 16. Discarded loads never issue.
- R10: A committed store that has not yet been written still blocks loads to its word. Such a load can issue in the cycle after the store's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_ready | output | 1 | A free slot exists |
| alloc_slot | output | 4 | Slot the next allocation receives |
| agen_valid | input | 1 | Effective address write |
| agen_slot | input | 4 | Slot being given its address |
| agen_addr | input | 32 | Effective address |
| ld_issue_valid | output | 1 | A load is sent to the cache this cycle |
| ld_issue_slot | output | 4 | Slot of the issuing load |
| ld_issue_addr | output | 32 | Address of the issuing load |
| commit_valid | input | 1 | Commit the oldest uncommitted entry |
| st_write_valid | output | 1 | A committed store writes memory this cycle |
| st_write_addr | output | 32 | Address of that store |
| flush_valid | input | 1 | Discard entries younger than `flush_slot` |
| flush_slot | input | 4 | Youngest slot that survives the flush |

## Verification
On every cycle the assertions check the following:
- the occupancy never exceeds 16 entries;
- the commit pointer stays inside the occupied range;
- any issued load is a load whose address is known, and it is marked issued on the next cycle;
- a store write always retires exactly the head entry;
- the selector never grants two loads at once.

Only the bench's scenarios can show the ordering outcomes:
- that an unknown or same-word older store actually holds a load back;
- that the oldest of several ready loads wins;
- that a committed store keeps blocking until its write;
- that a flush renumbers the tail.

The behavioural queue model checks these outcomes cycle by cycle under random traffic.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int LSQ_DEPTH = 16;
    localparam int LSQ_AW    = 32;

    typedef struct packed {
        logic              is_st;
        logic              known;
        logic              issued;
        logic              cmt;
        logic [LSQ_AW-1:0] addr;
    } lsq_entry_t;

    // Two accesses alias when they fall in the same 32-bit word.
    function automatic logic same_word(input logic [LSQ_AW-1:0] a,
                                       input logic [LSQ_AW-1:0] b);
        return a[LSQ_AW-1:2] == b[LSQ_AW-1:2];
    endfunction

endpackage

// File: rtl/lsq_alias_check.sv
module lsq_alias_check
    import lsq_pkg::*;
#(
    parameter int DEPTH = LSQ_DEPTH,
    localparam int IW   = $clog2(DEPTH)
) (
    input  lsq_entry_t       ent [DEPTH],
    input  logic [IW-1:0]    head_idx,
    input  logic [IW:0]      count,
    output logic [DEPTH-1:0] ld_ok
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [IW-1:0] SLOT = IW'(i);

        always_comb begin
            logic [IW-1:0] age_i;
            logic [IW-1:0] age_j;
            logic          blk;
            age_i = SLOT - head_idx;
            blk   = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                age_j = IW'(j) - head_idx;
                // Any older store blocks unless its address is known and in another word.
                if (age_j < age_i && ent[j].is_st &&
                    (!ent[j].known || same_word(ent[j].addr, ent[i].addr)))
                    blk = 1'b1;
            end
            ld_ok[i] = ({1'b0, age_i} < count) && !ent[i].is_st &&
                       ent[i].known && !ent[i].issued && !blk;
        end
    end

endmodule

// File: rtl/lsq_oldest_pick.sv
module lsq_oldest_pick #(
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] req,
    input  logic [IW-1:0]    head_idx,
    output logic             gnt_valid,
    output logic [IW-1:0]    gnt_idx
);

    logic [DEPTH-1:0] gnt_oh;

    always_comb begin
        logic [IW-1:0] idx;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        gnt_oh    = '0;
        // Scan from the head so that the oldest requester wins.
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_idx + IW'(k);
            if (!gnt_valid && req[idx]) begin
                gnt_valid   = 1'b1;
                gnt_idx     = idx;
                gnt_oh[idx] = 1'b1;
            end
        end
    end

    a_r6_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_oh) && (gnt_valid == (req != '0)));

endmodule

// File: rtl/lsq_dep_check.sv
module lsq_dep_check
    import lsq_pkg::*;
#(
    parameter int DEPTH = LSQ_DEPTH,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic              alloc_is_store,
    output logic              alloc_ready,
    output logic [IW-1:0]     alloc_slot,
    input  logic              agen_valid,
    input  logic [IW-1:0]     agen_slot,
    input  logic [LSQ_AW-1:0] agen_addr,
    output logic              ld_issue_valid,
    output logic [IW-1:0]     ld_issue_slot,
    output logic [LSQ_AW-1:0] ld_issue_addr,
    input  logic              commit_valid,
    output logic              st_write_valid,
    output logic [LSQ_AW-1:0] st_write_addr,
    input  logic              flush_valid,
    input  logic [IW-1:0]     flush_slot
);

    localparam logic [PW-1:0] FULL = PW'(DEPTH);

    lsq_entry_t       ent [DEPTH];
    logic [PW-1:0]    head_q, tail_q, cptr_q, count;
    logic [IW-1:0]    head_idx, tail_idx, cptr_idx, flush_age;
    logic             drain, alloc_fire;
    logic [DEPTH-1:0] ld_ok;

    always_comb begin
        count          = tail_q - head_q;
        head_idx       = head_q[IW-1:0];
        tail_idx       = tail_q[IW-1:0];
        cptr_idx       = cptr_q[IW-1:0];
        flush_age      = flush_slot - head_idx;
        alloc_ready    = (count != FULL);
        alloc_slot     = tail_idx;
        alloc_fire     = alloc_valid && alloc_ready && !flush_valid;
        drain          = (count != '0) && ent[head_idx].cmt;
        st_write_valid = drain && ent[head_idx].is_st;
        st_write_addr  = ent[head_idx].addr;
        ld_issue_addr  = ent[ld_issue_slot].addr;
    end

    lsq_alias_check #(.DEPTH(DEPTH)) i_alias (
        .ent      (ent),
        .head_idx (head_idx),
        .count    (count),
        .ld_ok    (ld_ok)
    );

    lsq_oldest_pick #(.DEPTH(DEPTH)) i_pick (
        .clk       (clk),
        .rst       (rst),
        .req       (ld_ok),
        .head_idx  (head_idx),
        .gnt_valid (ld_issue_valid),
        .gnt_idx   (ld_issue_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            if (ld_issue_valid) ent[ld_issue_slot].issued <= 1'b1;
            if (agen_valid) begin
                ent[agen_slot].known <= 1'b1;
                ent[agen_slot].addr  <= agen_addr;
            end
            if (commit_valid) begin
                ent[cptr_idx].cmt <= 1'b1;
                cptr_q            <= cptr_q + 1'b1;
            end
            if (drain) head_q <= head_q + 1'b1;
            if (flush_valid) begin
                tail_q <= head_q + {1'b0, flush_age} + 1'b1;
            end else if (alloc_fire) begin
                ent[tail_idx] <= '{is_st: alloc_is_store, known: 1'b0,
                                   issued: 1'b0, cmt: 1'b0, addr: '0};
                tail_q        <= tail_q + 1'b1;
            end
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= FULL);

    a_r7_commit_in_range: assert property (@(posedge clk) disable iff (rst)
        (cptr_q - head_q) <= count);

    a_r7_write_retires_head: assert property (@(posedge clk) disable iff (rst)
        st_write_valid |=> head_q == $past(head_q) + 1'b1);

    a_r3_issue_has_addr: assert property (@(posedge clk) disable iff (rst)
        ld_issue_valid |-> (!ent[ld_issue_slot].is_st && ent[ld_issue_slot].known));

    a_r6_issue_marked: assert property (@(posedge clk) disable iff (rst)
        ld_issue_valid |=> ent[$past(ld_issue_slot)].issued);

endmodule

// File: tb/test_lsq_dep_check.sv
module test_lsq_dep_check;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_valid = 0, alloc_is_store = 0;
    logic        agen_valid = 0, commit_valid = 0, flush_valid = 0;
    logic [3:0]  agen_slot = '0, flush_slot = '0;
    logic [31:0] agen_addr = '0;
    logic        alloc_ready, ld_issue_valid, st_write_valid;
    logic [3:0]  alloc_slot, ld_issue_slot;
    logic [31:0] ld_issue_addr, st_write_addr;

    lsq_dep_check i_lsq_dep_check (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
        .alloc_ready(alloc_ready), .alloc_slot(alloc_slot),
        .agen_valid(agen_valid), .agen_slot(agen_slot), .agen_addr(agen_addr),
        .ld_issue_valid(ld_issue_valid), .ld_issue_slot(ld_issue_slot),
        .ld_issue_addr(ld_issue_addr), .commit_valid(commit_valid),
        .st_write_valid(st_write_valid), .st_write_addr(st_write_addr),
        .flush_valid(flush_valid), .flush_slot(flush_slot)
    );

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        int          slot;
        bit          st;
        bit          known;
        logic [31:0] addr;
        bit          issued;
        bit          cmt;
    } m_t;

    m_t q[$];
    int next_slot = 0;

    bit          e_ready, e_lv, e_sv;
    int          e_slot, e_ls;
    logic [31:0] e_la, e_sa;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected outputs from the model's current contents.
    function automatic void model_calc();
        e_ready = q.size() < 16;
        e_slot  = next_slot;
        e_sv    = q.size() > 0 && q[0].cmt && q[0].st;
        e_sa    = (q.size() > 0) ? q[0].addr : 32'h0;
        e_lv    = 0;
        e_ls    = 0;
        e_la    = 0;
        for (int i = 0; i < q.size(); i++) begin
            if (!e_lv && !q[i].st && q[i].known && !q[i].issued) begin
                bit blk = 0;
                for (int j = 0; j < i; j++)
                    if (q[j].st && (!q[j].known || q[j].addr[31:2] == q[i].addr[31:2]))
                        blk = 1;
                if (!blk) begin
                    e_lv = 1;
                    e_ls = q[i].slot;
                    e_la = q[i].addr;
                end
            end
        end
    endfunction

    function automatic int find_slot(input int s);
        for (int i = 0; i < q.size(); i++) if (q[i].slot == s) return i;
        return -1;
    endfunction

    function automatic void model_edge();
        int  sz;
        bit  drn;
        int  k;
        m_t  e;
        model_calc();
        sz  = q.size();
        drn = sz > 0 && q[0].cmt;
        if (e_lv) begin
            k = find_slot(e_ls);
            q[k].issued = 1;
        end
        if (agen_valid) begin
            k = find_slot(int'(agen_slot));
            if (k >= 0) begin
                q[k].known = 1;
                q[k].addr  = agen_addr;
            end
        end
        if (commit_valid) begin
            for (int i = 0; i < q.size(); i++)
                if (!q[i].cmt) begin
                    q[i].cmt = 1;
                    break;
                end
        end
        if (flush_valid) begin
            k = find_slot(int'(flush_slot));
            while (q.size() > k + 1) void'(q.pop_back());
            next_slot = (int'(flush_slot) + 1) % 16;
        end
        if (drn) void'(q.pop_front());
        if (alloc_valid && !flush_valid && sz < 16) begin
            e = '{slot: next_slot, st: alloc_is_store, known: 0, addr: 0, issued: 0, cmt: 0};
            q.push_back(e);
            next_slot = (next_slot + 1) % 16;
        end
    endfunction

    task automatic compare_all();
        model_calc();
        chk(alloc_ready == e_ready, "R2", "alloc_ready", 32'(alloc_ready), 32'(e_ready));
        chk(int'(alloc_slot) == e_slot, "R2", "alloc_slot", 32'(alloc_slot), 32'(e_slot));
        chk(ld_issue_valid == e_lv, "R6", "ld_issue_valid", 32'(ld_issue_valid), 32'(e_lv));
        if (e_lv) begin
            chk(int'(ld_issue_slot) == e_ls, "R6", "ld_issue_slot", 32'(ld_issue_slot), 32'(e_ls));
            chk(ld_issue_addr == e_la, "R6", "ld_issue_addr", ld_issue_addr, e_la);
        end
        chk(st_write_valid == e_sv, "R7", "st_write_valid", 32'(st_write_valid), 32'(e_sv));
        if (e_sv) chk(st_write_addr == e_sa, "R7", "st_write_addr", st_write_addr, e_sa);
    endtask

    // One clock: the model follows the inputs at the edge, outputs are compared after it.
    task automatic tick();
        @(posedge clk);
        model_edge();
        #2;
        alloc_valid = 0; alloc_is_store = 0; agen_valid = 0;
        commit_valid = 0; flush_valid = 0;
        compare_all();
    endtask

    task automatic do_alloc(input bit st);
        alloc_valid = 1; alloc_is_store = st; tick();
    endtask
    task automatic do_agen(input int s, input logic [31:0] a);
        agen_valid = 1; agen_slot = 4'(s); agen_addr = a; tick();
    endtask
    task automatic do_commit();
        commit_valid = 1; tick();
    endtask
    task automatic do_flush(input int s);
        flush_valid = 1; flush_slot = 4'(s); tick();
    endtask

    function automatic logic [31:0] pick_addr();
        case ($urandom % 6)
            0: return 32'h1000;
            1: return 32'h1004;
            2: return 32'h1008;
            3: return 32'h1002;
            4: return 32'h2000;
            default: return 32'h1006;
        endcase
    endfunction

    task automatic random_cycle();
        int r = int'($urandom % 100);
        int ncmt = 0;
        int lo;
        int k;
        int unk[$];
        for (int i = 0; i < q.size(); i++) if (q[i].cmt) ncmt++;
        if (q.size() > 0 && r < 3) begin
            lo = (ncmt > 0) ? ncmt - 1 : 0;
            k  = lo + int'($urandom % (q.size() - lo));
            flush_valid = 1;
            flush_slot  = 4'(q[k].slot);
        end else begin
            alloc_valid    = $urandom % 2;
            alloc_is_store = ($urandom % 3) == 0;
            for (int i = 0; i < q.size(); i++) if (!q[i].known) unk.push_back(i);
            if (unk.size() > 0 && $urandom % 2 == 1) begin
                k          = unk[$urandom % unk.size()];
                agen_valid = 1;
                agen_slot  = 4'(q[k].slot);
                agen_addr  = pick_addr();
            end
            for (int i = 0; i < q.size(); i++)
                if (!q[i].cmt) begin
                    if (q[i].known && (q[i].st || q[i].issued) && $urandom % 3 != 0)
                        commit_valid = 1;
                    break;
                end
        end
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        compare_all();
        // R1: empty after reset
        chk(alloc_ready == 1 && alloc_slot == 0, "R1", "ready/slot after reset",
            {27'b0, alloc_ready, alloc_slot}, 32'h10);
        chk(!ld_issue_valid && !st_write_valid, "R1", "no issue/write after reset",
            {30'b0, ld_issue_valid, st_write_valid}, 32'h0);

        // Store s0, loads s1 and s2
        do_alloc(1); do_alloc(0); do_alloc(0);
        do_agen(1, 32'h100);
        chk(!ld_issue_valid, "R4", "load held by unknown older store", 32'(ld_issue_valid), 0);
        do_agen(0, 32'h104);
        chk(ld_issue_valid && ld_issue_slot == 1, "R3", "load issues after address known",
            32'(ld_issue_slot), 1);
        chk(ld_issue_addr == 32'h100, "R5", "different word passes", ld_issue_addr, 32'h100);
        do_agen(2, 32'h106);
        chk(!ld_issue_valid, "R5", "same word, different low bits blocks", 32'(ld_issue_valid), 0);
        do_commit();
        chk(st_write_valid && st_write_addr == 32'h104, "R7", "committed store written at head",
            st_write_addr, 32'h104);
        chk(!ld_issue_valid, "R10", "undrained committed store still blocks", 32'(ld_issue_valid), 0);
        tick();
        chk(ld_issue_valid && ld_issue_slot == 2, "R10", "load issues after store write",
            32'(ld_issue_slot), 2);
        do_commit();
        do_commit();
        chk(!st_write_valid, "R8", "committed load drains without write", 32'(st_write_valid), 0);
        tick();
        chk(!st_write_valid, "R8", "second load drains without write", 32'(st_write_valid), 0);
        tick();

        // Ordering: store s3, loads s4 and s5
        do_alloc(1); do_alloc(0); do_alloc(0);
        do_agen(4, 32'h10);
        chk(!ld_issue_valid, "R4", "older store without address blocks", 32'(ld_issue_valid), 0);
        do_agen(5, 32'h20);
        do_agen(3, 32'h30);
        chk(ld_issue_valid && ld_issue_slot == 4, "R6", "oldest ready load first",
            32'(ld_issue_slot), 4);
        tick();
        chk(ld_issue_valid && ld_issue_slot == 5, "R6", "next load second",
            32'(ld_issue_slot), 5);
        tick();
        chk(!ld_issue_valid, "R3", "load issued only once", 32'(ld_issue_valid), 0);
        do_commit();
        chk(st_write_valid && st_write_addr == 32'h30, "R7", "store write address",
            st_write_addr, 32'h30);
        tick();

        // Flush
        do_alloc(0); do_alloc(0);
        do_flush(5);
        chk(alloc_slot == 6, "R9", "tail renumbered after flush", 32'(alloc_slot), 6);
        chk(!ld_issue_valid, "R9", "discarded loads do not issue", 32'(ld_issue_valid), 0);
        do_alloc(0);
        do_agen(6, 32'h44);
        chk(ld_issue_valid && ld_issue_slot == 6 && ld_issue_addr == 32'h44, "R9",
            "reallocated slot issues fresh load", ld_issue_addr, 32'h44);
        do_commit(); do_commit(); do_commit();
        tick(); tick(); tick();

        // Fill
        for (int i = 0; i < 16; i++) do_alloc(0);
        chk(!alloc_ready, "R2", "full after 16 allocations", 32'(alloc_ready), 0);
        do_alloc(0);
        chk(!alloc_ready && alloc_slot == 7, "R2", "allocation while full ignored",
            32'(alloc_slot), 7);
        do_flush(7);
        chk(alloc_ready && alloc_slot == 8, "R9", "flush to oldest entry", 32'(alloc_slot), 8);
        do_agen(7, 32'h50);
        tick();
        do_commit();
        tick(); tick();

        for (int c = 0; c < 4000; c++) random_cycle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule